// File: doc/BRIEF.md
# System Control Register File

This block is a bank of processor control and status registers. A core or a debug agent reaches it through one write port and one read port, and each port selects a register by index. A register can be an ordinary stored word, a stored word whose writes pass through a merge mask, a hardwired identification constant, or a write-only alias that scatters its byte into another register. One index range is reserved and unimplemented. Touching it reads as zero, stores nothing, and raises a one-cycle error pulse. A write to the access-control register that switches a coprocessor off raises the same pulse.

The write and read ports are plain control pins with no valid/ready handshake. A write is always accepted and takes effect at the next rising clock edge. A read is combinational and never stalls, so there is no back-pressure. The index map is as follows: 0 is the execution-state register, 1 system control, 2 the boot-value copy, 3 access control, 4 floating-point exception, 5 floating-point status/control, 6 the event mailbox, 7 the condition-block alias, 8 to 11 the identification constants, 12 to 15 the general scratch words, 16 to 31 the unimplemented range, and 32 to 63 lie past the table. The boot strap input gives the reset value of selected system-control bits.

Top module: `sysreg_bank`

## Requirements
- R1: While rst_n is low, every register clears to zero, with these exceptions. The execution-state register resets to 0x00000010 (user mode in bits 4:0). The mailbox (index 6) resets to 1. The boot copy (index 2) resets to boot_strap. System control (index 1) resets to boot_strap AND 0x48002000, which keeps bits 30, 27 and 13 of the strap.
- R2: A write to system control (index 1) replaces every bit except bit 27, which keeps its current value.
- R3: A write to the floating-point exception register (index 4) changes only bits 30:29. All other bits keep their old value.
- R4: A write to floating-point status/control (index 5) changes only the bits in mask 0x04F7009F. These are the sticky flags in bits 4:0 and bit 7, the vector length in bits 18:16, the stride in bits 21:20, the rounding mode in bits 23:22 and the half-precision format in bit 26. All other bits are preserved.
- R5: A write to the alias (index 7) copies wr_data bits 1:0 into execution-state bits 26:25 and wr_data bits 7:2 into execution-state bits 15:10. The other execution-state bits are unchanged. The alias itself always reads 0.
- R6: A write to access control (index 3) stores only bits 23:20 (mask 0x00F00000). If bits 21:20 or bits 23:22 of the written value differ from 3, err is high in the next cycle.
- R7: Index 8 reads 0x00000031, index 9 reads 0x00000003, index 10 reads 0x86468006 and index 11 reads 0x00000001. Writes to these indices have no effect.
- R8: A read with rd_en high, or a write, to an index from 16 to 31 raises err for exactly the next cycle. Such an index stores nothing and reads 0.
- R9: Indices 32 to 63 read 0, drop writes and never raise err.
- R10: rd_data follows rd_idx combinationally. A read in the same cycle as a write to the same index returns the old value, and the new value is visible after the edge.
- R11: The execution-state register (index 0), the boot copy (index 2), the mailbox (index 6) and the scratch words (indices 12 to 15) take full 32-bit writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_strap | input | 32 | Boot value for system-control bits and the boot copy |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, used only for error detection |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 32 | Combinational read data |
| err | output | 1 | One-cycle pulse after an unimplemented access or a rejected access-control write |

## Verification
Two error sources can land in one cycle. A read of an unimplemented index can coincide with an access-control write that disables a coprocessor, and the two must merge into a single one-cycle err pulse while the masked access-control value is still stored. The bench drives both strobes in one cycle, then samples err one cycle later (high) and two cycles later (low), and reads back the stored access-control value. It also writes system control while reading it in the same cycle, to confirm that the read returns the old word and that the new word, with bit 27 kept, appears after the edge.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DW = 32;

  localparam int IX_STATUS     = 0;
  localparam int IX_SCTL       = 1;
  localparam int IX_SCTL_BOOT  = 2;
  localparam int IX_ACCESS     = 3;
  localparam int IX_FPX        = 4;
  localparam int IX_FPSC       = 5;
  localparam int IX_MAILBOX    = 6;
  localparam int IX_COND       = 7;
  localparam int IX_ID_PF0     = 8;
  localparam int IX_ID_MM0     = 9;
  localparam int IX_CACHE_TYPE = 10;
  localparam int IX_TLB_TYPE   = 11;
  localparam int FIRST_SCRATCH = 12;

  localparam logic [DW-1:0] STATUS_RST     = 32'h0000_0010;
  localparam logic [DW-1:0] SCTL_BOOT_MASK = 32'h4800_2000;
  localparam logic [DW-1:0] SCTL_KEEP      = 32'h0800_0000;
  localparam logic [DW-1:0] FPX_MASK       = 32'h6000_0000;
  localparam logic [DW-1:0] FPSC_MASK      = 32'h04F7_009F;
  localparam logic [DW-1:0] ACC_MASK       = 32'h00F0_0000;

  typedef enum logic [3:0] {
    K_PLAIN, K_STATUS, K_SCTL, K_BOOT, K_ACCESS,
    K_FPX, K_FPSC, K_MAILBOX, K_ALIAS, K_CONST
  } cell_kind_e;

  function automatic cell_kind_e kind_of(input int e);
    case (e)
      IX_STATUS:    return K_STATUS;
      IX_SCTL:      return K_SCTL;
      IX_SCTL_BOOT: return K_BOOT;
      IX_ACCESS:    return K_ACCESS;
      IX_FPX:       return K_FPX;
      IX_FPSC:      return K_FPSC;
      IX_MAILBOX:   return K_MAILBOX;
      IX_COND:      return K_ALIAS;
      IX_ID_PF0, IX_ID_MM0, IX_CACHE_TYPE, IX_TLB_TYPE: return K_CONST;
      default:      return K_PLAIN;
    endcase
  endfunction

  function automatic logic [DW-1:0] const_of(input int e);
    case (e)
      IX_ID_PF0:     return 32'h0000_0031;
      IX_ID_MM0:     return 32'h0000_0003;
      IX_CACHE_TYPE: return 32'h8646_8006;
      IX_TLB_TYPE:   return 32'h0000_0001;
      default:       return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] masked_merge(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] new_v,
                                                 input logic [DW-1:0] mask);
    return (new_v & mask) | (old_v & ~mask);
  endfunction

  function automatic logic [DW-1:0] cond_scatter(input logic [DW-1:0] old_v,
                                                 input logic [7:0] b);
    logic [DW-1:0] r;
    r = old_v;
    r[26:25] = b[1:0];
    r[15:10] = b[7:2];
    return r;
  endfunction
endpackage

// File: rtl/sysreg_cell.sv
module sysreg_cell
  import sysreg_pkg::*;
#(
  parameter int ENTRY = 0,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    boot_strap,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    q
);
  localparam cell_kind_e        KIND    = kind_of(ENTRY);
  localparam logic [IDX_W-1:0]  MY_IX   = IDX_W'(ENTRY);
  localparam logic [IDX_W-1:0]  COND_IX = IDX_W'(IX_COND);

  generate
    if (KIND == K_CONST) begin : g_const
      wire unused_c = ^{clk, rst_n, boot_strap, wr_en, wr_idx, wr_data};
      assign q = const_of(ENTRY);
    end else if (KIND == K_ALIAS) begin : g_alias
      wire unused_a = ^{clk, rst_n, boot_strap, wr_en, wr_idx, wr_data};
      assign q = '0;
    end else begin : g_store
      logic [DW-1:0] q_r, nxt, rst_val;
      logic          upd;
      logic          hit, alias_hit;

      assign hit       = wr_en && (wr_idx == MY_IX);
      assign alias_hit = wr_en && (wr_idx == COND_IX);

      always_comb begin
        rst_val = '0;
        nxt     = wr_data;
        upd     = hit;
        case (KIND)
          K_STATUS: begin
            rst_val = STATUS_RST;
            if (alias_hit) begin
              upd = 1'b1;
              nxt = cond_scatter(q_r, wr_data[7:0]);
            end
          end
          K_SCTL: begin
            rst_val = boot_strap & SCTL_BOOT_MASK;
            nxt     = masked_merge(q_r, wr_data, ~SCTL_KEEP);
          end
          K_BOOT:    rst_val = boot_strap;
          K_ACCESS:  nxt = wr_data & ACC_MASK;
          K_FPX:     nxt = masked_merge(q_r, wr_data, FPX_MASK);
          K_FPSC:    nxt = masked_merge(q_r, wr_data, FPSC_MASK);
          K_MAILBOX: rst_val = 32'h0000_0001;
          default:   nxt = wr_data;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q_r <= rst_val;
        else if (upd) q_r <= nxt;
      end

      assign q = q_r;
    end
  endgenerate
endmodule

// File: rtl/sysreg_rdmux.sv
module sysreg_rdmux
  import sysreg_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int NUM_TBL = 16
) (
  input  logic [NUM_TBL-1:0][DW-1:0] tbl,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [DW-1:0]              rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_TBL; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = tbl[i];
    end
  end
endmodule

// File: rtl/sysreg_guard.sv
module sysreg_guard
  import sysreg_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int UNIMP_LO = 16,
  parameter int UNIMP_HI = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             err
);
  localparam logic [IDX_W-1:0] ACC_IX = IDX_W'(IX_ACCESS);

  function automatic logic in_unimp(input logic [IDX_W-1:0] ix);
    return (int'(ix) >= UNIMP_LO) && (int'(ix) < UNIMP_HI);
  endfunction

  logic rd_bad, wr_bad, acc_bad, err_q;
  wire  unused_g = ^{wr_data[31:24], wr_data[19:0]};

  assign rd_bad  = rd_en && in_unimp(rd_idx);
  assign wr_bad  = wr_en && in_unimp(wr_idx);
  assign acc_bad = wr_en && (wr_idx == ACC_IX) &&
                   ((wr_data[21:20] != 2'b11) || (wr_data[23:22] != 2'b11));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= rd_bad || wr_bad || acc_bad;
  end

  assign err = err_q;
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int SCRATCH_N = 4,
  parameter int UNIMP_LO  = 16,
  parameter int UNIMP_HI  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    boot_strap,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic             err
);
  localparam int NUM_TBL = FIRST_SCRATCH + SCRATCH_N;

  logic [NUM_TBL-1:0][DW-1:0] tbl;

  generate
    for (genvar g = 0; g < NUM_TBL; g++) begin : g_cell
      sysreg_cell #(.ENTRY(g), .IDX_W(IDX_W)) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_strap(boot_strap),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .q         (tbl[g])
      );
    end
  endgenerate

  sysreg_rdmux #(.IDX_W(IDX_W), .NUM_TBL(NUM_TBL)) u_rdmux (
    .tbl    (tbl),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  sysreg_guard #(.IDX_W(IDX_W), .UNIMP_LO(UNIMP_LO), .UNIMP_HI(UNIMP_HI)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .err    (err)
  );
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk
  import sysreg_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int NUM_TBL  = 16,
  parameter int UNIMP_LO = 16,
  parameter int UNIMP_HI = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [DW-1:0]              wr_data,
  input logic                       rd_en,
  input logic [IDX_W-1:0]           rd_idx,
  input logic [DW-1:0]              rd_data,
  input logic                       err,
  input logic [NUM_TBL-1:0][DW-1:0] tbl
);
  logic wr_unimp, rd_unimp, acc_reject;
  assign wr_unimp   = wr_en && (int'(wr_idx) >= UNIMP_LO) && (int'(wr_idx) < UNIMP_HI);
  assign rd_unimp   = rd_en && (int'(rd_idx) >= UNIMP_LO) && (int'(rd_idx) < UNIMP_HI);
  assign acc_reject = wr_en && (int'(wr_idx) == IX_ACCESS) &&
                      (wr_data[23:20] != 4'hF);

  // R2
  sctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(tbl[IX_SCTL][27]));
  // R3
  fpx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl[IX_FPX] & ~FPX_MASK) == '0);
  // R4
  fpsc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl[IX_FPSC] & ~FPSC_MASK) == '0);
  // R6
  acc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl[IX_ACCESS] & ~ACC_MASK) == '0);
  // R6
  acc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_reject |=> err);
  // R8
  unimp_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unimp |=> err);
  // R8
  unimp_rd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unimp |=> err);
  // R5
  alias_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) == IX_COND) |-> (rd_data == '0));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (tbl == $past(tbl)));
endmodule

bind sysreg_bank sysreg_bank_chk #(
  .IDX_W(IDX_W), .NUM_TBL(NUM_TBL), .UNIMP_LO(UNIMP_LO), .UNIMP_HI(UNIMP_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .err(err), .tbl(tbl)
);

// File: tb/sim_sysreg_bank.sv
`timescale 1ns/1ps
module sim_sysreg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] boot_strap = 32'hFFFF_FFFF;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        err;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sysreg_bank u0 (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .err(err)
  );

  // {req4, wr_idx6, wr_data32, chk_idx6, expected32, err1}
  localparam int NV = 19;
  localparam logic [80:0] VEC [NV] = '{
    {4'd2,  6'd1,  32'h0000_0000, 6'd1,  32'h0800_0000, 1'b0}, // R2
    {4'd2,  6'd1,  32'hFFFF_FFFF, 6'd1,  32'hFFFF_FFFF, 1'b0}, // R2
    {4'd3,  6'd4,  32'hFFFF_FFFF, 6'd4,  32'h6000_0000, 1'b0}, // R3
    {4'd3,  6'd4,  32'h2000_0001, 6'd4,  32'h2000_0000, 1'b0}, // R3
    {4'd4,  6'd5,  32'hFFFF_FFFF, 6'd5,  32'h04F7_009F, 1'b0}, // R4
    {4'd4,  6'd5,  32'h0000_0100, 6'd5,  32'h0000_0000, 1'b0}, // R4
    {4'd5,  6'd7,  32'h0000_00FF, 6'd0,  32'h0600_FC10, 1'b0}, // R5
    {4'd5,  6'd7,  32'h0000_0006, 6'd0,  32'h0400_0410, 1'b0}, // R5
    {4'd5,  6'd7,  32'h0000_0055, 6'd7,  32'h0000_0000, 1'b0}, // R5
    {4'd6,  6'd3,  32'hFFFF_FFFF, 6'd3,  32'h00F0_0000, 1'b0}, // R6
    {4'd6,  6'd3,  32'h0000_0000, 6'd3,  32'h0000_0000, 1'b1}, // R6
    {4'd7,  6'd8,  32'h0000_0000, 6'd8,  32'h0000_0031, 1'b0}, // R7
    {4'd7,  6'd11, 32'h0000_0000, 6'd11, 32'h0000_0001, 1'b0}, // R7
    {4'd11, 6'd12, 32'hA5A5_A5A5, 6'd12, 32'hA5A5_A5A5, 1'b0}, // R11
    {4'd11, 6'd15, 32'h0000_BEEF, 6'd15, 32'h0000_BEEF, 1'b0}, // R11
    {4'd8,  6'd20, 32'h1234_5678, 6'd20, 32'h0000_0000, 1'b1}, // R8
    {4'd9,  6'd40, 32'h0000_1234, 6'd40, 32'h0000_0000, 1'b0}, // R9
    {4'd11, 6'd6,  32'h0000_0000, 6'd6,  32'h0000_0000, 1'b0}, // R11
    {4'd11, 6'd0,  32'h0000_001F, 6'd0,  32'h0000_001F, 1'b0}  // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] i, input logic [31:0] exp);
    rd_idx = i; #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] old_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 status reset", 6'd0, 32'h0000_0010);
    rd_chk("R1 sctl reset", 6'd1, 32'h4800_2000);
    rd_chk("R1 boot copy", 6'd2, 32'hFFFF_FFFF);
    rd_chk("R1 mailbox reset", 6'd6, 32'h0000_0001);
    rd_chk("R1 fpsc reset", 6'd5, 32'h0000_0000);
    check("R1 err reset", {31'b0, err}, 32'h0);
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][76:71], VEC[k][70:39]);
      check($sformatf("R%0d vec%0d err", VEC[k][80:77], k), {31'b0, err}, {31'b0, VEC[k][0]});
      rd_chk($sformatf("R%0d vec%0d data", VEC[k][80:77], k), VEC[k][38:33], VEC[k][32:1]);
      @(negedge clk);
    end

    // R7 remaining constants
    rd_chk("R7 mm0", 6'd9, 32'h0000_0003);
    rd_chk("R7 cache type", 6'd10, 32'h8646_8006);

    // R10 same-cycle write and read of system control
    rd_idx = 6'd1; #1; old_v = rd_data;
    check("R10 pre value", old_v, 32'hFFFF_FFFF);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd1; wr_data = 32'h1234_5678; rd_idx = 6'd1; #1;
    check("R10 old value same cycle", rd_data, 32'hFFFF_FFFF);
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk("R10 R2 new value", 6'd1, 32'h1A34_5678);
    @(negedge clk);

    // R8 R6 unimplemented read coinciding with rejected access write
    rd_en = 1'b1; rd_idx = 6'd17;
    wr_en = 1'b1; wr_idx = 6'd3; wr_data = 32'h0030_0000; #1;
    check("R8 unimp read data", rd_data, 32'h0);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R8 R6 merged err high", {31'b0, err}, 32'h1);
    rd_chk("R6 stored masked", 6'd3, 32'h0030_0000);
    @(negedge clk);
    check("R8 err one cycle", {31'b0, err}, 32'h0);

    // R8 lone unimplemented read
    rd_en = 1'b1; rd_idx = 6'd31;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 read err", {31'b0, err}, 32'h1);

    // R9 read past table raises nothing
    rd_en = 1'b1; rd_idx = 6'd50;
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 no err", {31'b0, err}, 32'h0);
    rd_chk("R9 zero", 6'd50, 32'h0);

    // R1 second reset with other strap
    boot_strap = 32'h4000_0000;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 sctl strap", 6'd1, 32'h4000_0000);
    rd_chk("R1 status again", 6'd0, 32'h0000_0010);
    rd_chk("R1 scratch cleared", 6'd12, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule